// File: doc/BRIEF.md
# Directory CAS Forwarding Queue

This block sits at the directory of one heavily contended cache line. It removes the serial hand-off that lock-free compare-and-swap loops usually suffer. Each core issues a load of the old value before its CAS. The block puts these loads in arrival order. A core sends its new value as soon as it decodes the CAS and the value exists. The block then answers each queued load with the new value of the entry just ahead of it, so every core can run its CAS speculatively at the same time instead of waiting for the line.

Validation never ships the line to the cores. A single validate pulse walks the whole queue from the head, with the line's current value as the running reference. An entry whose answer matches the reference commits, and its new value becomes the reference for the next entry. The first entry whose answer disagrees is squashed, and so is every answered entry behind it. Squashed entries keep their places and are answered again from the corrected chain. When forwarding is switched off, only the head of the queue is ever answered, and the line passes from core to core one at a time.

Top module: `cas_fwd_dir`

## Requirements
- R1: Load-old requests join the queue in the order they arrive. Requests in the same cycle join in ascending core index, so the lowest index goes first.
- R2: While `eager_en_i` is 0, only the entry at the head of the queue is answered, and it is answered with the line value. Later entries wait until they become head.
- R3: While `eager_en_i` is 1, the head is answered with the line value, and the entry at position i is answered with the new value stored for position i-1. An answer is a one-cycle pulse on that core's bit of `rsp_valid_o`, with the value in that core's 32-bit lane of `rsp_data_o`. Lane c occupies bits c*DATA_W and up. Each entry is answered at most once between validations that affect it.
- R4: A core may forward its new value at any time through `fwd_i`/`fwd_data_i`. The most recently forwarded value replaces any earlier one.
- R5: A validate pulse walks the queue from the head, starting with the line value as the reference. An entry that has been answered, has forwarded, and whose answer equals the reference commits, and its new value becomes the next reference. The walk stops without any action at the first entry that is unanswered or has not forwarded. Commit pulses appear on `commit_o` in the cycle after the validate pulse.
- R6: After a validate pulse that commits entries, `line_o` holds the new value of the last committed entry. In all other cycles, `line_o` changes only through R10.
- R7: In a validation walk, the first answered entry whose answer differs from the reference gets a squash pulse. Every answered entry behind it gets one too. Squashed entries stay queued in order and are answered again.
- R8: An entry behind the head is not answered until the entry just ahead of it has forwarded a value.
- R9: Each core holds at most one queue entry. A request from a core that is already queued is ignored.
- R10: An external write (`wr_i`) replaces the line value, except in a cycle where validation commits entries.
- R11: After reset, no answer, commit or squash pulses are issued, the queue is empty, and `line_o` equals `LINE_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| eager_en_i | input | 1 | 1: answer successors with forwarded values; 0: serial hand-off |
| req_i | input | NUM_CORES | Per-core load-old request pulse |
| fwd_i | input | NUM_CORES | Per-core forward-new-value pulse |
| fwd_data_i | input | NUM_CORES*DATA_W | Forwarded new values, one lane per core |
| validate_i | input | 1 | Start a validation walk over the queue |
| wr_i | input | 1 | External write to the line |
| wr_data_i | input | DATA_W | External write value |
| rsp_valid_o | output | NUM_CORES | Per-core answer pulse |
| rsp_data_o | output | NUM_CORES*DATA_W | Answer values, one lane per core |
| commit_o | output | NUM_CORES | Per-core commit pulse |
| squash_o | output | NUM_CORES | Per-core squash pulse |
| line_o | output | DATA_W | Current line value |

## Verification
A wrong queue order or a lost forwarded value shows up at the next answer: a successor's response lane carries some value other than its predecessor's forward, within two cycles of the forward. A bad validation reference shows up one cycle after the validate pulse, as a commit where a squash belongs or the reverse, and `line_o` differs from the newest committed value. A stale answered flag shows as a missing or doubled answer after a squash or a commit. The bench watches the per-core answer counts for this.

// File: rtl/cfq_pkg.sv
package cfq_pkg;

  typedef enum logic [1:0] {
    VERDICT_NONE   = 2'd0,
    VERDICT_COMMIT = 2'd1,
    VERDICT_SQUASH = 2'd2
  } verdict_e;

  function automatic int idx_bits(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/cfq_order.sv
// Arrival-order queue of core indices: pops committed heads, appends new
// requesters in ascending core index.
module cfq_order
  import cfq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = idx_bits(NUM_CORES),
  localparam int CNT_W = idx_bits(NUM_CORES + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_i,
  input  logic [NUM_CORES-1:0]              push_i,
  input  logic [CNT_W-1:0]                  pop_i,
  output logic [NUM_CORES-1:0][IDX_W-1:0]   order_o,
  output logic [CNT_W-1:0]                  count_o
);

  logic [NUM_CORES-1:0][IDX_W-1:0] order_q, order_d;
  logic [CNT_W-1:0]                count_q, count_d;

  always_comb begin
    int fill;
    int src;
    order_d = '0;
    for (int p = 0; p < NUM_CORES; p++) begin
      src = p + int'(pop_i);
      if (src < int'(count_q)) order_d[p] = order_q[src];
    end
    fill = int'(count_q) - int'(pop_i);
    for (int c = 0; c < NUM_CORES; c++) begin
      if (push_i[c] && fill < NUM_CORES) begin
        order_d[fill] = IDX_W'(c);
        fill++;
      end
    end
    count_d = CNT_W'(fill);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      order_q <= '0;
      count_q <= '0;
    end else begin
      order_q <= order_d;
      count_q <= count_d;
    end
  end

  assign order_o = order_q;
  assign count_o = count_q;

endmodule

// File: rtl/cfq_answer.sv
// Chooses which queued entries get answered this cycle and with what value.
module cfq_answer
  import cfq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = idx_bits(NUM_CORES),
  localparam int CNT_W = idx_bits(NUM_CORES + 1)
) (
  input  logic [NUM_CORES-1:0][IDX_W-1:0]  order_i,
  input  logic [CNT_W-1:0]                 count_i,
  input  logic [DATA_W-1:0]                line_i,
  input  logic [NUM_CORES-1:0]             fwd_have_i,
  input  logic [NUM_CORES-1:0]             ans_have_i,
  input  logic [NUM_CORES-1:0][DATA_W-1:0] new_i,
  input  logic                             eager_i,
  input  logic                             hold_i,
  output logic [NUM_CORES-1:0]             ans_now_o,
  output logic [NUM_CORES-1:0][DATA_W-1:0] ans_val_o
);

  always_comb begin
    int prev;
    ans_now_o = '0;
    ans_val_o = '0;
    for (int p = 0; p < NUM_CORES; p++) begin
      prev = (p == 0) ? 0 : p - 1;
      if (!hold_i && p < int'(count_i) && !ans_have_i[order_i[p]]) begin
        if (p == 0) begin
          ans_now_o[order_i[p]] = 1'b1;
          ans_val_o[order_i[p]] = line_i;
        end else if (eager_i && fwd_have_i[order_i[prev]]) begin
          ans_now_o[order_i[p]] = 1'b1;
          ans_val_o[order_i[p]] = new_i[order_i[prev]];
        end
      end
    end
  end

endmodule

// File: rtl/cfq_validate.sv
// One-pass validation walk: commits the matching prefix, squashes from the
// first answered mismatch onward.
module cfq_validate
  import cfq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = idx_bits(NUM_CORES),
  localparam int CNT_W = idx_bits(NUM_CORES + 1)
) (
  input  logic [NUM_CORES-1:0][IDX_W-1:0]  order_i,
  input  logic [CNT_W-1:0]                 count_i,
  input  logic [DATA_W-1:0]                line_i,
  input  logic [NUM_CORES-1:0]             fwd_have_i,
  input  logic [NUM_CORES-1:0]             ans_have_i,
  input  logic [NUM_CORES-1:0][DATA_W-1:0] new_i,
  input  logic [NUM_CORES-1:0][DATA_W-1:0] ans_i,
  output verdict_e [NUM_CORES-1:0]         verdict_o,
  output logic [CNT_W-1:0]                 pop_o,
  output logic [DATA_W-1:0]                line_o
);

  always_comb begin
    logic [DATA_W-1:0] ref_v;
    logic              walking;
    logic              broken;
    int                done;
    ref_v   = line_i;
    walking = 1'b1;
    broken  = 1'b0;
    done    = 0;
    for (int c = 0; c < NUM_CORES; c++) verdict_o[c] = VERDICT_NONE;
    for (int p = 0; p < NUM_CORES; p++) begin
      if (p < int'(count_i)) begin
        if (walking) begin
          if (ans_have_i[order_i[p]] && ans_i[order_i[p]] != ref_v) begin
            verdict_o[order_i[p]] = VERDICT_SQUASH;
            walking = 1'b0;
            broken  = 1'b1;
          end else if (ans_have_i[order_i[p]] && fwd_have_i[order_i[p]]) begin
            verdict_o[order_i[p]] = VERDICT_COMMIT;
            ref_v = new_i[order_i[p]];
            done++;
          end else begin
            walking = 1'b0;
          end
        end else if (broken && ans_have_i[order_i[p]]) begin
          verdict_o[order_i[p]] = VERDICT_SQUASH;
        end
      end
    end
    pop_o  = CNT_W'(done);
    line_o = ref_v;
  end

endmodule

// File: rtl/cas_fwd_dir.sv
module cas_fwd_dir
  import cfq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] LINE_INIT = '0
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic                          eager_en_i,
  input  logic [NUM_CORES-1:0]          req_i,
  input  logic [NUM_CORES-1:0]          fwd_i,
  input  logic [NUM_CORES*DATA_W-1:0]   fwd_data_i,
  input  logic                          validate_i,
  input  logic                          wr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [NUM_CORES-1:0]          rsp_valid_o,
  output logic [NUM_CORES*DATA_W-1:0]   rsp_data_o,
  output logic [NUM_CORES-1:0]          commit_o,
  output logic [NUM_CORES-1:0]          squash_o,
  output logic [DATA_W-1:0]             line_o
);

  localparam int IDX_W = idx_bits(NUM_CORES);
  localparam int CNT_W = idx_bits(NUM_CORES + 1);

  logic [NUM_CORES-1:0][DATA_W-1:0] fwd_data_w, new_w, ans_w, ans_val_w, rsp_data_q;
  logic [NUM_CORES-1:0]             queued_w, fwd_have_w, ans_have_w, ans_now_w;
  logic [NUM_CORES-1:0]             push_w, commit_w, squash_w;
  logic [NUM_CORES-1:0]             rsp_valid_q, commit_q, squash_q;
  verdict_e [NUM_CORES-1:0]         verdict_w;
  logic [NUM_CORES-1:0][IDX_W-1:0]  order_w;
  logic [CNT_W-1:0]                 count_w, pop_raw_w, pop_w;
  logic [DATA_W-1:0]                line_q, line_next_w;

  assign fwd_data_w = fwd_data_i;
  assign push_w     = req_i & ~queued_w;
  assign pop_w      = validate_i ? pop_raw_w : '0;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      commit_w[c] = validate_i && (verdict_w[c] == VERDICT_COMMIT);
      squash_w[c] = validate_i && (verdict_w[c] == VERDICT_SQUASH);
    end
  end

  cfq_order #(.NUM_CORES(NUM_CORES)) i_order (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .push_i  (push_w),
    .pop_i   (pop_w),
    .order_o (order_w),
    .count_o (count_w)
  );

  cfq_answer #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) i_answer (
    .order_i    (order_w),
    .count_i    (count_w),
    .line_i     (line_q),
    .fwd_have_i (fwd_have_w),
    .ans_have_i (ans_have_w),
    .new_i      (new_w),
    .eager_i    (eager_en_i),
    .hold_i     (validate_i),
    .ans_now_o  (ans_now_w),
    .ans_val_o  (ans_val_w)
  );

  cfq_validate #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) i_validate (
    .order_i    (order_w),
    .count_i    (count_w),
    .line_i     (line_q),
    .fwd_have_i (fwd_have_w),
    .ans_have_i (ans_have_w),
    .new_i      (new_w),
    .ans_i      (ans_w),
    .verdict_o  (verdict_w),
    .pop_o      (pop_raw_w),
    .line_o     (line_next_w)
  );

  // Per-core slot: queued flag, forwarded value, value handed out as answer.
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
    logic              queued_q, fwd_have_q, ans_have_q;
    logic [DATA_W-1:0] new_q, ans_q;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        queued_q   <= 1'b0;
        fwd_have_q <= 1'b0;
        ans_have_q <= 1'b0;
        new_q      <= '0;
        ans_q      <= '0;
      end else if (commit_w[c]) begin
        queued_q   <= 1'b0;
        fwd_have_q <= 1'b0;
        ans_have_q <= 1'b0;
      end else begin
        if (push_w[c]) queued_q <= 1'b1;
        if (fwd_i[c]) begin
          fwd_have_q <= 1'b1;
          new_q      <= fwd_data_w[c];
        end
        if (squash_w[c]) begin
          ans_have_q <= 1'b0;
        end else if (ans_now_w[c]) begin
          ans_have_q <= 1'b1;
          ans_q      <= ans_val_w[c];
        end
      end
    end

    assign queued_w[c]   = queued_q;
    assign fwd_have_w[c] = fwd_have_q;
    assign ans_have_w[c] = ans_have_q;
    assign new_w[c]      = new_q;
    assign ans_w[c]      = ans_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rsp_valid_q <= '0;
      rsp_data_q  <= '0;
      commit_q    <= '0;
      squash_q    <= '0;
      line_q      <= LINE_INIT;
    end else begin
      rsp_valid_q <= ans_now_w;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (ans_now_w[c]) rsp_data_q[c] <= ans_val_w[c];
      end
      commit_q <= commit_w;
      squash_q <= squash_w;
      if (pop_w != '0) line_q <= line_next_w;
      else if (wr_i)   line_q <= wr_data_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign commit_o    = commit_q;
  assign squash_o    = squash_q;
  assign line_o      = line_q;

endmodule

// File: rtl/cas_fwd_dir_checker.sv
module cas_fwd_dir_checker #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W = 32
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic                 eager_en_i,
  input logic                 validate_i,
  input logic                 wr_i,
  input logic [NUM_CORES-1:0] rsp_valid_o,
  input logic [NUM_CORES-1:0] commit_o,
  input logic [NUM_CORES-1:0] squash_o,
  input logic [DATA_W-1:0]    line_o
);

  AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
    (commit_o & squash_o) == '0); // R7

  AST_NO_RSP_WITH_OUTCOME: assert property (@(posedge clk_i) disable iff (rst_i)
    (rsp_valid_o & (commit_o | squash_o)) == '0); // R5

  AST_RSP_NOT_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (rst_i)
    (rsp_valid_o != '0) |=> ((rsp_valid_o & $past(rsp_valid_o)) == '0)); // R3

  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!validate_i && !wr_i) |=> $stable(line_o)); // R6

  AST_COMMIT_NEEDS_VALIDATE: assert property (@(posedge clk_i) disable iff (rst_i)
    (commit_o != '0 || squash_o != '0) |-> $past(validate_i)); // R5

  AST_SERIAL_SINGLE_RSP: assert property (@(posedge clk_i) disable iff (rst_i)
    !eager_en_i |=> ($countones(rsp_valid_o) <= 1)); // R2

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    rst_i |=> (rsp_valid_o == '0 && commit_o == '0 && squash_o == '0)); // R11

endmodule

bind cas_fwd_dir cas_fwd_dir_checker #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) i_checker (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .eager_en_i  (eager_en_i),
  .validate_i  (validate_i),
  .wr_i        (wr_i),
  .rsp_valid_o (rsp_valid_o),
  .commit_o    (commit_o),
  .squash_o    (squash_o),
  .line_o      (line_o)
);

// File: tb/test_cas_fwd_dir.sv
`timescale 1ns/1ps
module test_cas_fwd_dir;

  localparam int N = 4;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           eager = 1'b1;
  logic [N-1:0]   req = '0;
  logic [N-1:0]   fwd = '0;
  logic [N*W-1:0] fwd_data = '0;
  logic           validate = 1'b0;
  logic           wr = 1'b0;
  logic [W-1:0]   wr_data = '0;
  logic [N-1:0]   rsp_valid, commit, squash;
  logic [N*W-1:0] rsp_data;
  logic [W-1:0]   line;

  int nchk = 0;
  int nbad = 0;
  int rsp_cnt[N];
  int commit_cnt[N];
  int squash_cnt[N];
  logic [W-1:0] rsp_last[N];
  logic [W-1:0] exp_line;

  always #4 clk = ~clk;

  cas_fwd_dir #(.NUM_CORES(N), .DATA_W(W)) i_cas_fwd_dir (
    .clk_i(clk), .rst_i(rst), .eager_en_i(eager), .req_i(req), .fwd_i(fwd),
    .fwd_data_i(fwd_data), .validate_i(validate), .wr_i(wr), .wr_data_i(wr_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .commit_o(commit),
    .squash_o(squash), .line_o(line)
  );

  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < N; c++) begin
        if (rsp_valid[c]) begin
          rsp_cnt[c]++;
          rsp_last[c] = rsp_data[c*W +: W];
        end
        if (commit[c]) commit_cnt[c]++;
        if (squash[c]) squash_cnt[c]++;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic clear_logs();
    for (int c = 0; c < N; c++) begin
      rsp_cnt[c] = 0; commit_cnt[c] = 0; squash_cnt[c] = 0; rsp_last[c] = '0;
    end
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_req(logic [N-1:0] m);
    req = m; tick(1); req = '0;
  endtask

  task automatic send_fwd(int c, logic [W-1:0] v);
    fwd[c] = 1'b1; fwd_data[c*W +: W] = v; tick(1); fwd = '0;
  endtask

  task automatic do_validate();
    validate = 1'b1; tick(1); validate = 1'b0;
  endtask

  task automatic do_write(logic [W-1:0] v);
    wr = 1'b1; wr_data = v; tick(1); wr = 1'b0;
  endtask

  function automatic logic [N-1:0] bit_of(int c);
    return N'(1) << c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, c2, b2, x;
    void'($urandom(32'd4242));
    clear_logs();
    tick(4);
    rst = 1'b0;
    tick(2);
    // R11 reset state
    check("R11 rsp_valid", W'(rsp_valid), '0);
    check("R11 commit", W'(commit), '0);
    check("R11 squash", W'(squash), '0);
    check("R11 line", line, '0);
    exp_line = '0;

    // R3 R5 R6 random orders, forwards sent back to front
    for (int r = 0; r < 8; r++) begin
      int perm[N];
      logic [W-1:0] v[N];
      logic [W-1:0] base;
      for (int i = 0; i < N; i++) perm[i] = i;
      for (int i = N - 1; i > 0; i--) begin
        int j, t;
        j = int'($urandom % (i + 1));
        t = perm[i]; perm[i] = perm[j]; perm[j] = t;
      end
      for (int i = 0; i < N; i++) v[i] = $urandom;
      clear_logs();
      base = exp_line;
      for (int k = 0; k < N; k++) send_req(bit_of(perm[k]));
      for (int k = N - 1; k >= 0; k--) send_fwd(perm[k], v[k]);
      tick(4);
      check("R3 head answer", rsp_last[perm[0]], base);
      for (int k = 1; k < N; k++) begin
        check("R3 successor answer", rsp_last[perm[k]], v[k-1]);
        check("R3 single answer", W'(rsp_cnt[perm[k]]), 1);
      end
      do_validate();
      tick(3);
      for (int k = 0; k < N; k++) check("R5 commit", W'(commit_cnt[perm[k]]), 1);
      check("R7 no squash", W'(squash_cnt[0] + squash_cnt[1] + squash_cnt[2] + squash_cnt[3]), 0);
      check("R6 line after commit", line, v[N-1]);
      exp_line = v[N-1];
    end

    // R7 R10 external write makes the head stale: whole chain squashed
    clear_logs();
    a = $urandom; b = $urandom; c2 = $urandom;
    send_req(bit_of(0)); send_req(bit_of(1)); send_req(bit_of(2));
    send_fwd(0, a); send_fwd(1, b); send_fwd(2, c2);
    tick(4);
    x = ~exp_line;
    do_write(x);
    tick(1);
    check("R10 line after write", line, x);
    do_validate();
    tick(3);
    for (int k = 0; k < 3; k++) begin
      check("R7 squash chain", W'(squash_cnt[k]), 1);
      check("R7 no commit on squash", W'(commit_cnt[k]), 0);
      check("R7 re-answered", W'(rsp_cnt[k]), 2);
    end
    check("R7 head re-answer", rsp_last[0], x);
    check("R7 second re-answer", rsp_last[1], a);
    check("R7 third re-answer", rsp_last[2], b);
    do_validate();
    tick(3);
    for (int k = 0; k < 3; k++) check("R5 commit after retry", W'(commit_cnt[k]), 1);
    check("R6 line after retry", line, c2);
    exp_line = c2;

    // R4 R7 middle entry changes its value: tail squashed, prefix commits
    clear_logs();
    a = $urandom; b = $urandom; c2 = $urandom; b2 = ~b;
    send_req(bit_of(0)); send_req(bit_of(1)); send_req(bit_of(2));
    send_fwd(0, a); send_fwd(1, b); send_fwd(2, c2);
    tick(4);
    send_fwd(1, b2);
    do_validate();
    tick(3);
    check("R5 commit core0", W'(commit_cnt[0]), 1);
    check("R4 commit core1", W'(commit_cnt[1]), 1);
    check("R7 squash core2", W'(squash_cnt[2]), 1);
    check("R7 no commit core2", W'(commit_cnt[2]), 0);
    check("R4 line is latest forward", line, b2);
    check("R7 tail re-answered", rsp_last[2], b2);
    do_validate();
    tick(3);
    check("R5 tail commit", W'(commit_cnt[2]), 1);
    check("R6 line tail", line, c2);
    exp_line = c2;

    // R8 successor waits for predecessor forward
    clear_logs();
    a = $urandom; b = $urandom;
    send_req(bit_of(3)); send_req(bit_of(0));
    tick(4);
    check("R8 successor waits", W'(rsp_cnt[0]), 0);
    check("R3 head answered", W'(rsp_cnt[3]), 1);
    send_fwd(3, a);
    tick(3);
    check("R8 answered after forward", W'(rsp_cnt[0]), 1);
    check("R8 answer value", rsp_last[0], a);
    do_validate();
    tick(3);
    check("R5 head commit", W'(commit_cnt[3]), 1);
    check("R5 stop at unforwarded", W'(commit_cnt[0]), 0);
    check("R5 no squash at stop", W'(squash_cnt[0]), 0);
    check("R6 line", line, a);
    send_fwd(0, b);
    do_validate();
    tick(3);
    check("R5 late commit", W'(commit_cnt[0]), 1);
    check("R6 line late", line, b);
    exp_line = b;

    // R2 serial mode
    eager = 1'b0;
    clear_logs();
    a = $urandom; b = $urandom;
    send_req(bit_of(1)); send_req(bit_of(2));
    send_fwd(1, a); send_fwd(2, b);
    tick(4);
    check("R2 head answered", rsp_last[1], exp_line);
    check("R2 successor held", W'(rsp_cnt[2]), 0);
    do_validate();
    tick(4);
    check("R2 head commit", W'(commit_cnt[1]), 1);
    check("R2 new head answered", W'(rsp_cnt[2]), 1);
    check("R2 new head value", rsp_last[2], a);
    do_validate();
    tick(3);
    check("R2 second commit", W'(commit_cnt[2]), 1);
    check("R6 line serial", line, b);
    exp_line = b;
    eager = 1'b1;

    // R1 same-cycle requests ordered by core index
    clear_logs();
    a = $urandom; b = $urandom;
    send_req(4'b0110);
    send_fwd(2, a); send_fwd(1, b);
    tick(4);
    check("R1 lower index is head", rsp_last[1], exp_line);
    check("R1 higher index follows", rsp_last[2], b);
    do_validate();
    tick(3);
    check("R1 line", line, a);
    exp_line = a;

    // R9 duplicate request ignored; R4 latest forward wins
    clear_logs();
    a = $urandom; b = ~a;
    send_req(bit_of(3));
    tick(1);
    send_req(bit_of(3));
    send_fwd(3, a);
    send_fwd(3, b);
    tick(2);
    do_validate();
    tick(5);
    check("R9 one answer", W'(rsp_cnt[3]), 1);
    check("R9 one commit", W'(commit_cnt[3]), 1);
    check("R4 latest value committed", line, b);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule